// File: doc/BRIEF.md
# Radio Event Timer with 40-bit Time Base

This block keeps the time base used to schedule radio activity. A 16-bit sub-period counter advances once per clock while the timer runs. After it holds the programmed period value it returns to zero, and a 24-bit period counter then advances by one. Together the two counters form a 40-bit time value. Software sets the block up through a simple register port: it selects the period, the compare values and the run state, and it can preload the period counter.

Two compare units watch the sub-period counter and two watch the period counter. When a counter steps onto a compare value, that unit emits a one-clock strobe. The strobes can start reception or transmission, or they can act as interrupt sources. Each compare strobe also sets a sticky flag. A capture unit latches the full 40-bit time in a single clock. It is triggered either by a start-of-frame event or by a transmit-end event, and a control bit picks which one.

Top module: `radio_evt_timer`

## Requirements
- R1: After reset both counters read 0, all flags read 0, all compare strobes and `irq` are low, and the period register (address 1) reads 0xFFFF.
- R2: With the run bit (CTRL bit 0, address 0) at 1, the sub-period counter (address 2) advances by one per clock. With the run bit at 0, both counters hold their values.
- R3: If the sub-period counter equals the period value on a running clock, the next clock sets it to 0 and raises the period counter (address 3) by one on that same clock.
- R4: A write to address 3 loads the period counter only while the timer is stopped. The same write is ignored while the timer runs.
- R5: Sub-period compare unit k (value at address 6+k, enable at CTRL bit 2+k) drives `sub_strobe[k]` high for exactly the one clock in which the counter has just stepped onto its value. A disabled unit, or a counter that is stopped, gives no strobe.
- R6: Period compare unit k (value at address 8+k, enable at CTRL bit 4+k) drives `per_strobe[k]` high for one clock. That clock is the one right after the wrap that brings the period counter onto its value.
- R7: The flag register (address 10) holds sticky bits: bits 1:0 for the sub-period strobes and bits 3:2 for the period strobes. Writing a 1 to a bit clears it, and a new set in the same clock takes priority over the clear. `irq` is the OR of all the flag bits.
- R8: When CTRL bit 1 is 0, a start-of-frame pulse captures the counters. When it is 1, a transmit-end pulse captures them instead, and the other input is ignored. The capture stores the sub-period value (address 4) and the period value (address 5) as they stood in the event clock, so a wrap on that same clock cannot split them.
- R9: Each capture sets flag bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sof_evt | input | 1 | Start-of-frame event pulse |
| txend_evt | input | 1 | Transmit-end event pulse |
| sub_strobe | output | 2 | Sub-period compare strobes |
| per_strobe | output | 2 | Period compare strobes |
| irq | output | 1 | OR of the sticky flags |

## Verification
The hardest case to reach is a capture that falls on the same clock as a wrap, when the sub-period counter returns to zero and the period counter carries. A torn capture would show up only there. The stimulus gets there by loading a short period and stepping the running timer to the exact clock on which the sub-period counter holds the period value. The transmit-end event is raised on that clock, and the bench expects the pre-wrap pair in the capture registers. Each period compare strobe is reached in a similar way: the period counter is preloaded just below the compare value, so only one or two wraps are needed.

// File: rtl/radio_evt_pkg.sv
// Shared register addresses and control bit positions for the radio event timer.
package radio_evt_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 4'd1;
    localparam logic [ADDR_W-1:0] A_SUBCNT = 4'd2;
    localparam logic [ADDR_W-1:0] A_PERCNT = 4'd3;
    localparam logic [ADDR_W-1:0] A_CAPSUB = 4'd4;
    localparam logic [ADDR_W-1:0] A_CAPPER = 4'd5;
    localparam logic [ADDR_W-1:0] A_SCMP0  = 4'd6;
    localparam logic [ADDR_W-1:0] A_PCMP0  = 4'd8;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd10;

    localparam int NCMP     = 2;            // compare units per counter
    localparam int CTRL_W   = 2 + 2*NCMP;   // run, select, enables
    localparam int FLAG_W   = 2*NCMP + 1;   // strobe flags plus capture flag
    localparam int B_RUN    = 0;
    localparam int B_SEL    = 1;
    localparam int B_EN0    = 2;
endpackage

// File: rtl/evt_timebase.sv
// Two-stage time base: a sub-period counter wrapping at a programmable
// period, and a period counter that advances on each wrap.
// Assumes period is static enough that software changes it only when stopped.
module evt_timebase #(
    parameter int SUB_W = 16,
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SUB_W-1:0] period,
    input  logic             per_load,
    input  logic [PER_W-1:0] per_load_val,
    output logic [SUB_W-1:0] sub_cnt,
    output logic [PER_W-1:0] per_cnt,
    output logic             sub_adv,
    output logic [SUB_W-1:0] sub_nxt,
    output logic             per_adv,
    output logic [PER_W-1:0] per_nxt
);
    logic wrap;

    // Next-state values and advance qualifiers for both stages.
    always_comb begin
        wrap    = (sub_cnt == period);
        sub_nxt = wrap ? '0 : sub_cnt + 1'b1;
        per_nxt = per_cnt + 1'b1;
        sub_adv = run;
        per_adv = run & wrap;
    end

    // Counter registers: count when running, accept a preload when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cnt <= '0;
            per_cnt <= '0;
        end else if (run) begin
            sub_cnt <= sub_nxt;
            if (wrap) per_cnt <= per_nxt;
        end else if (per_load) begin
            per_cnt <= per_load_val;
        end
    end
endmodule

// File: rtl/evt_compare.sv
// Equality compare unit: registers a one-clock strobe when its counter is
// about to step onto the compare value, so the strobe coincides with it.
module evt_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         adv,
    input  logic [W-1:0] nxt,
    input  logic [W-1:0] cmp_val,
    output logic         strobe
);
    // Strobe register: high only after an advance onto the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= en & adv & (nxt == cmp_val);
    end
endmodule

// File: rtl/evt_capture.sv
// Atomic timestamp register: latches the whole time value in one clock.
module evt_capture #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic [W-1:0] stamp,
    output logic [W-1:0] cap,
    output logic         hit
);
    // Capture register loads the full stamp on a trigger clock.
    always_ff @(posedge clk) begin
        if (!rst_n)    cap <= '0;
        else if (trig) cap <= stamp;
    end

    assign hit = trig;
endmodule

// File: rtl/radio_evt_timer.sv
// Radio event timer top: register port, two-stage time base, compare sets
// on each stage, sticky flags and an event-triggered 40-bit capture.
// Assumes single-clock event pulses synchronous to clk.
module radio_evt_timer
    import radio_evt_pkg::*;
#(
    parameter int SUB_W = 16,
    parameter int PER_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sof_evt,
    input  logic              txend_evt,
    output logic [NCMP-1:0]   sub_strobe,
    output logic [NCMP-1:0]   per_strobe,
    output logic              irq
);
    localparam int TIME_W = SUB_W + PER_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [SUB_W-1:0]  period_q;
    logic [SUB_W-1:0]  scmp_q [NCMP];
    logic [PER_W-1:0]  pcmp_q [NCMP];
    logic [FLAG_W-1:0] flags_q;

    logic              run_q, sel_q;
    logic [SUB_W-1:0]  sub_cnt, sub_nxt;
    logic [PER_W-1:0]  per_cnt, per_nxt;
    logic              sub_adv, per_adv;
    logic [TIME_W-1:0] cap_q;
    logic              cap_hit, cap_trig;
    logic              per_load;
    logic [FLAG_W-1:0] flag_set, flag_clr;

    assign run_q    = ctrl_q[B_RUN];
    assign sel_q    = ctrl_q[B_SEL];
    assign per_load = reg_we && (reg_addr == A_PERCNT);
    assign cap_trig = sel_q ? txend_evt : sof_evt;

    // Configuration registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= '1;
            for (int k = 0; k < NCMP; k++) begin
                scmp_q[k] <= '0;
                pcmp_q[k] <= '0;
            end
        end else if (reg_we) begin
            if (reg_addr == A_CTRL)   ctrl_q   <= reg_wdata[CTRL_W-1:0];
            if (reg_addr == A_PERIOD) period_q <= reg_wdata[SUB_W-1:0];
            for (int k = 0; k < NCMP; k++) begin
                if (reg_addr == A_SCMP0 + ADDR_W'(k)) scmp_q[k] <= reg_wdata[SUB_W-1:0];
                if (reg_addr == A_PCMP0 + ADDR_W'(k)) pcmp_q[k] <= reg_wdata[PER_W-1:0];
            end
        end
    end

    evt_timebase #(.SUB_W(SUB_W), .PER_W(PER_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run_q), .period(period_q),
        .per_load(per_load), .per_load_val(reg_wdata[PER_W-1:0]),
        .sub_cnt(sub_cnt), .per_cnt(per_cnt),
        .sub_adv(sub_adv), .sub_nxt(sub_nxt),
        .per_adv(per_adv), .per_nxt(per_nxt)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        evt_compare #(.W(SUB_W)) u_sub (
            .clk(clk), .rst_n(rst_n), .en(ctrl_q[B_EN0+g]),
            .adv(sub_adv), .nxt(sub_nxt), .cmp_val(scmp_q[g]),
            .strobe(sub_strobe[g])
        );
        evt_compare #(.W(PER_W)) u_per (
            .clk(clk), .rst_n(rst_n), .en(ctrl_q[B_EN0+NCMP+g]),
            .adv(per_adv), .nxt(per_nxt), .cmp_val(pcmp_q[g]),
            .strobe(per_strobe[g])
        );
    end

    evt_capture #(.W(TIME_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .trig(cap_trig),
        .stamp({per_cnt, sub_cnt}), .cap(cap_q), .hit(cap_hit)
    );

    // Flag set/clear vectors; a set beats a clear on the same clock.
    always_comb begin
        flag_set = {cap_hit, per_strobe, sub_strobe};
        flag_clr = (reg_we && reg_addr == A_FLAGS) ? reg_wdata[FLAG_W-1:0] : '0;
    end

    // Sticky flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    assign irq = |flags_q;

    // Read multiplexer, zero-extended.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
            A_PERIOD: reg_rdata[SUB_W-1:0]  = period_q;
            A_SUBCNT: reg_rdata[SUB_W-1:0]  = sub_cnt;
            A_PERCNT: reg_rdata[PER_W-1:0]  = per_cnt;
            A_CAPSUB: reg_rdata[SUB_W-1:0]  = cap_q[SUB_W-1:0];
            A_CAPPER: reg_rdata[PER_W-1:0]  = cap_q[TIME_W-1:SUB_W];
            A_FLAGS:  reg_rdata[FLAG_W-1:0] = flags_q;
            default: begin
                for (int k = 0; k < NCMP; k++) begin
                    if (reg_addr == A_SCMP0 + ADDR_W'(k)) reg_rdata[SUB_W-1:0] = scmp_q[k];
                    if (reg_addr == A_PCMP0 + ADDR_W'(k)) reg_rdata[PER_W-1:0] = pcmp_q[k];
                end
            end
        endcase
    end
endmodule

// File: rtl/radio_evt_timer_chk.sv
// Checker for the radio event timer, bound to the top module.
module radio_evt_timer_chk
    import radio_evt_pkg::*;
#(
    parameter int SUB_W = 16,
    parameter int PER_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              sel,
    input logic [SUB_W-1:0]  period,
    input logic [SUB_W-1:0]  sub_cnt,
    input logic [PER_W-1:0]  per_cnt,
    input logic [SUB_W-1:0]  scmp0,
    input logic [PER_W-1:0]  pcmp0,
    input logic [NCMP-1:0]   sub_strobe,
    input logic [NCMP-1:0]   per_strobe,
    input logic [FLAG_W-1:0] flags,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              sof_evt,
    input logic              txend_evt,
    input logic [SUB_W-1:0]  cap_sub,
    input logic [PER_W-1:0]  cap_per
);
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !(reg_we && reg_addr == A_PERCNT) |=> $stable(sub_cnt) && $stable(per_cnt)); // R2
    AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        run && sub_cnt == period |=> sub_cnt == '0 && per_cnt == PER_W'($past(per_cnt) + 1'b1)); // R3
    AST_LOAD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run && reg_we && reg_addr == A_PERCNT |=> per_cnt == $past(reg_wdata[PER_W-1:0])); // R4
    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        run && sub_cnt != period |=> per_cnt == $past(per_cnt)); // R4
    AST_SUB_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_strobe[0] |-> sub_cnt == $past(scmp0)); // R5
    AST_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        per_strobe[0] |-> per_cnt == $past(pcmp0) && sub_cnt == '0); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] && !(reg_we && reg_addr == A_FLAGS && reg_wdata[0]) |=> flags[0]); // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sub_strobe[0] |=> flags[0]); // R7
    AST_CAPTURE_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        sof_evt && !sel |=> cap_sub == $past(sub_cnt) && cap_per == $past(per_cnt)); // R8
    AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_evt && !sel) || (txend_evt && sel) |=> flags[FLAG_W-1]); // R9
endmodule

bind radio_evt_timer radio_evt_timer_chk #(.SUB_W(SUB_W), .PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sel(sel_q), .period(period_q),
    .sub_cnt(sub_cnt), .per_cnt(per_cnt), .scmp0(scmp_q[0]), .pcmp0(pcmp_q[0]),
    .sub_strobe(sub_strobe), .per_strobe(per_strobe), .flags(flags_q),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .sof_evt(sof_evt), .txend_evt(txend_evt),
    .cap_sub(cap_q[SUB_W-1:0]), .cap_per(cap_q[SUB_W+PER_W-1:SUB_W])
);

// File: tb/radio_evt_timer_bench.sv
`timescale 1ns/1ps
module radio_evt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sof_evt = 1'b0;
    logic        txend_evt = 1'b0;
    logic [1:0]  sub_strobe, per_strobe;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        int          kind;   // 0 register read, 1 strobes {per,sub}, 2 irq
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  mon_ev;

    always #2.5 clk = ~clk;

    radio_evt_timer u_radio_evt_timer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof_evt(sof_evt),
        .txend_evt(txend_evt), .sub_strobe(sub_strobe), .per_strobe(per_strobe),
        .irq(irq)
    );

    // Monitor: pop expected items and compare with what the design shows.
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = reg_rdata;
                    1: act = {28'd0, per_strobe, sub_strobe};
                    default: act = {31'd0, irq};
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver tasks; each assumes it starts shortly after a falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [3:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        #0.1;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
        #0.1;
    endtask

    task automatic chk_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
        expect_item(0, a, e, tag);
    endtask

    task automatic chk_strb(input logic [3:0] e, input string tag);
        expect_item(1, reg_addr, {28'd0, e}, tag);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        expect_item(2, reg_addr, {31'd0, e}, tag);
    endtask

    task automatic pulse_sof();
        sof_evt = 1'b1; @(posedge clk); @(negedge clk); sof_evt = 1'b0;
    endtask

    task automatic pulse_txend();
        txend_evt = 1'b1; @(posedge clk); @(negedge clk); txend_evt = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_reg(4'd2, 32'h0, "R1 sub counter");
        chk_reg(4'd3, 32'h0, "R1 period counter");
        chk_reg(4'd10, 32'h0, "R1 flags");
        chk_reg(4'd1, 32'h0000FFFF, "R1 period reg");
        chk_strb(4'b0000, "R1 strobes");
        chk_irq(1'b0, "R1 irq");

        // Configure while stopped
        wr(4'd1, 32'd4);
        wr(4'd3, 32'h100);
        chk_reg(4'd3, 32'h100, "R4 load while stopped");
        wr(4'd6, 32'd2);
        wr(4'd7, 32'd3);
        wr(4'd8, 32'h102);
        wr(4'd9, 32'h105);
        chk_reg(4'd2, 32'h0, "R2 held while stopped");

        // Run with sub0 and per0 enabled
        wr(4'd0, 32'h15);
        chk_reg(4'd2, 32'd0, "R2 start value");
        step(1);
        chk_reg(4'd2, 32'd1, "R2 count 1");
        step(1);
        chk_reg(4'd2, 32'd2, "R2 count 2");
        chk_strb(4'b0001, "R5 sub strobe on match");
        step(1);
        chk_strb(4'b0000, "R5 disabled unit silent");
        step(2);
        chk_reg(4'd2, 32'd0, "R3 wrap to zero");
        chk_reg(4'd3, 32'h101, "R3 carry");

        wr(4'd3, 32'hABCDEF);
        chk_reg(4'd3, 32'h101, "R4 load ignored while running");
        step(4);
        chk_strb(4'b0100, "R6 period strobe");
        chk_reg(4'd3, 32'h102, "R6 period value");
        step(1);
        chk_strb(4'b0000, "R6 single clock strobe");
        chk_reg(4'd10, 32'h5, "R7 sticky flags");
        chk_irq(1'b1, "R7 irq set");

        // Stop and hold
        wr(4'd0, 32'h14);
        step(3);
        chk_reg(4'd2, 32'd2, "R2 hold after stop");
        chk_strb(4'b0000, "R5 no strobe while stopped");
        wr(4'd10, 32'h1);
        chk_reg(4'd10, 32'h4, "R7 write one to clear");

        // Capture selection
        pulse_sof();
        chk_reg(4'd4, 32'd2, "R8 sof capture sub");
        chk_reg(4'd5, 32'h102, "R8 sof capture period");
        chk_reg(4'd10, 32'h14, "R9 capture flag");
        wr(4'd3, 32'h200);
        pulse_txend();
        chk_reg(4'd5, 32'h102, "R8 txend ignored when sof selected");
        wr(4'd0, 32'h16);
        pulse_txend();
        chk_reg(4'd5, 32'h200, "R8 txend capture period");
        chk_reg(4'd4, 32'd2, "R8 txend capture sub");

        // Capture on the wrap clock
        wr(4'd0, 32'h17);
        step(2);
        chk_reg(4'd2, 32'd4, "R3 at period value");
        pulse_txend();
        chk_reg(4'd4, 32'd4, "R8 atomic capture sub");
        chk_reg(4'd5, 32'h200, "R8 atomic capture period");
        chk_reg(4'd2, 32'd0, "R3 wrapped after capture");
        chk_reg(4'd3, 32'h201, "R3 carried after capture");

        wr(4'd10, 32'h1F);
        chk_reg(4'd10, 32'h0, "R7 clear all");
        chk_irq(1'b0, "R7 irq cleared");

        step(1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule